// File: doc/BRIEF.md
# SDRAM Command Sequencer with One-Shot Mode Set

This block sits between an internal bus and one SDRAM block. It turns each bus access that falls inside a programmable address window into a complete SDRAM command sequence. That sequence opens the row, issues one column command per data beat, and then closes the row. Longer internal transfers are cut into port-width beats by the sequencer. Every beat gets its own READ or WRITE command carrying a freshly computed column address, so the SDRAM is expected to be programmed for single-word bursts. Read data is taken from the SDRAM data pins after a programmable CAS latency and handed back on the bus with an acknowledge pulse.

Software programs the SDRAM mode register through an arm bit. A pulse on `armSet` arms the sequencer. The next access that hits the address window, whether it is a read or a write, is then issued as a single mode-register-set command. For that command the word address bits are placed on the SDRAM address pins unmultiplexed. The arm bit clears once the command goes out, and it can be read back on `armed` to confirm completion. An access outside the window is not taken and does not use up the arm.

Top module: `sdram_cmd_seq`

## Requirements
- R1: An access hits when `((busAddr ^ cfgBase) & ~cfgMask) == 0` (a set mask bit is a don't-care). A request that misses produces no command and no `busAck` for as long as it is held.
- R2: Commands appear on {sdCsN, sdRasN, sdCasN, sdWeN} as NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, MODE-SET=0000. NOP is driven in every clock without another command.
- R3: A normal hitting request sampled at a clock edge shows ACTIVE in the following clock with `sdAddr = busAddr[21:10]` (row). The first READ or WRITE follows exactly TRCD clocks after ACTIVE.
- R4: Size code 3 (16 bytes) gives four column commands in consecutive clocks with columns {busAddr[9:4], k} for k = 0..3. Size codes 0, 1 and 2 (1, 2 and 4 bytes) give one column command with column busAddr[9:2]. Column commands drive `sdAddr[10]` low.
- R5: For writes, `sdDqOe` is high only in WRITE clocks. In each WRITE clock `sdDqOut` equals the `busWdata` present when that beat was issued, and `busAck` pulses in the same clock.
- R6: For reads with latency CL = `cfgCasLat` (1..3), if READ is on the pins in clock n, then the value on `sdDqIn` at the end of clock n+CL appears on `busRdata` with a `busAck` pulse in clock n+CL+1. There is one pulse per beat.
- R7: PRECHARGE follows the clock after the last column command with `sdAddr[10]` high. No ACTIVE is issued fewer than TRP+1 clocks after a PRECHARGE or mode-set command.
- R8: A pulse on `armSet` makes `armed` read 1. The next hitting request, a read or a write of any size, shows a single MODE-SET command in the clock after it is sampled, with `sdAddr = busAddr[13:2]`. There is no ACTIVE, column or PRECHARGE command, exactly one `busAck` in that same clock, and `armed` reads 0 afterwards.
- R9: A request that misses the window leaves `armed` set and issues no MODE-SET.
- R10: After the mode-set access, the next hitting access runs the normal ACTIVE/column/PRECHARGE sequence.
- R11: During and right after reset, `armed`, `busAck` and `sdDqOe` are 0 and the command is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBase | input | ADDR_W | Window base address |
| cfgMask | input | ADDR_W | Window mask, 1 = ignore bit |
| cfgCasLat | input | 2 | CAS latency in clocks, 1 to 3 |
| armSet | input | 1 | Pulse to arm the mode-set |
| armed | output | 1 | Arm bit readback |
| busReq | input | 1 | Access request, held until the last acknowledge |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | 0:1 B, 1:2 B, 2:4 B, 3:16 B |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data of the current beat |
| busAck | output | 1 | One pulse per beat (one for a mode-set) |
| busRdata | output | DATA_W | Read data of the acknowledged beat |
| sdCsN | output | 1 | Chip select, low active |
| sdRasN | output | 1 | Row strobe, low active |
| sdCasN | output | 1 | Column strobe, low active |
| sdWeN | output | 1 | Write enable, low active |
| sdAddr | output | ROW_W | Multiplexed SDRAM address |
| sdDqOut | output | DATA_W | Write data to pins |
| sdDqOe | output | 1 | Data output enable |
| sdDqIn | input | DATA_W | Read data from pins |

## Verification
Reads are tried as single words at the shortest latency and as four-beat lines at latencies 2 and 3. Against a pin-level model that returns a column-dependent word only in the due clock, a mismatch points to either the column count or the capture cycle being wrong. Writes are tried as single words and as lines whose data changes on every acknowledge, which shows whether each beat takes its own data. The mode-set is triggered once by a word read and once by a line write, after a missing request has been held on an armed sequencer. This separates "the window blocks the arm" from "one ack regardless of size", and it confirms that the access that follows is normal again.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
  localparam int MAX_CL     = 3;
  localparam int RD_PIPE_D  = MAX_CL + 1;
  localparam int AP_BIT     = 10;
  localparam int LINE_BEATS = 4;
  localparam int BEAT_W     = $clog2(LINE_BEATS);
  localparam logic [1:0] SZ_LINE = 2'd3;

  // {cs, ras, cas, we}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_MRS = 4'b0000
  } sdCmd_e;

  typedef enum logic [1:0] {ASEL_ROW, ASEL_COL, ASEL_MODE, ASEL_PRE} addrSel_e;

  typedef struct packed {
    sdCmd_e              cmd;
    addrSel_e            addrSel;
    logic                latch;
    logic                wrBeat;
    logic                rdBeat;
    logic                modeAck;
    logic                line;
    logic [BEAT_W-1:0]   beat;
  } seqStrobe_t;
endpackage

// File: rtl/sdseq_ctrl.sv
module sdseq_ctrl
  import sdseq_pkg::*;
#(
  parameter int TRCD = 2,
  parameter int TRP  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busReq,
  input  logic        busWrite,
  input  logic [1:0]  busSize,
  input  logic        hit,
  input  logic        rdIdle,
  input  logic        armSet,
  output seqStrobe_t  st,
  output logic        armed
);
  localparam int CNT_MAX = (TRCD > TRP) ? TRCD : TRP;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RCD, S_BURST, S_PRE, S_RP} state_e;

  state_e             state, stateNxt;
  logic [CNT_W-1:0]   cnt, cntNxt;
  logic [BEAT_W-1:0]  beatIdx, beatNxt;
  logic [BEAT_W-1:0]  lastBeat;
  logic               isWrite, isLine;
  logic               armClr, doBeat;

  always_comb begin
    st = '{cmd: CMD_NOP, addrSel: ASEL_COL, latch: 1'b0, wrBeat: 1'b0,
           rdBeat: 1'b0, modeAck: 1'b0, line: isLine, beat: beatIdx};
    stateNxt = state;
    cntNxt   = cnt;
    beatNxt  = beatIdx;
    armClr   = 1'b0;
    doBeat   = 1'b0;
    case (state)
      S_IDLE: if (busReq && hit) begin
        if (armed) begin
          st.cmd     = CMD_MRS;
          st.addrSel = ASEL_MODE;
          st.modeAck = 1'b1;
          armClr     = 1'b1;
          cntNxt     = CNT_W'(TRP - 1);
          stateNxt   = S_RP;
        end else begin
          st.cmd     = CMD_ACT;
          st.addrSel = ASEL_ROW;
          st.latch   = 1'b1;
          cntNxt     = CNT_W'(TRCD - 1);
          beatNxt    = '0;
          stateNxt   = S_RCD;
        end
      end
      S_RCD: begin
        if (cnt == '0) doBeat = 1'b1;
        else           cntNxt = cnt - 1'b1;
      end
      S_BURST: doBeat = 1'b1;
      S_PRE: begin
        st.cmd     = CMD_PRE;
        st.addrSel = ASEL_PRE;
        cntNxt     = CNT_W'(TRP - 1);
        stateNxt   = S_RP;
      end
      S_RP: begin
        if (cnt != '0)  cntNxt   = cnt - 1'b1;
        else if (rdIdle) stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
    if (doBeat) begin
      st.cmd     = isWrite ? CMD_WR : CMD_RD;
      st.addrSel = ASEL_COL;
      st.wrBeat  = isWrite;
      st.rdBeat  = !isWrite;
      beatNxt    = beatIdx + 1'b1;
      stateNxt   = (beatIdx == lastBeat) ? S_PRE : S_BURST;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      beatIdx  <= '0;
      lastBeat <= '0;
      isWrite  <= 1'b0;
      isLine   <= 1'b0;
      armed    <= 1'b0;
    end else begin
      state   <= stateNxt;
      cnt     <= cntNxt;
      beatIdx <= beatNxt;
      if (st.latch) begin
        isWrite  <= busWrite;
        isLine   <= (busSize == SZ_LINE);
        lastBeat <= (busSize == SZ_LINE) ? BEAT_W'(LINE_BEATS - 1) : '0;
      end
      if (armSet)      armed <= 1'b1;
      else if (armClr) armed <= 1'b0;
    end
  end

  // Checker-side counters: clocks since the last ACTIVE / closing command.
  localparam int SINCE_W = $clog2(TRCD + TRP + 3) + 1;
  localparam logic [SINCE_W-1:0] SINCE_SAT = '1;
  logic [SINCE_W-1:0] sinceAct, sinceClose;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct   <= SINCE_SAT;
      sinceClose <= SINCE_SAT;
    end else begin
      if (st.cmd == CMD_ACT)          sinceAct <= SINCE_W'(1);
      else if (sinceAct != SINCE_SAT) sinceAct <= sinceAct + 1'b1;
      if (st.cmd == CMD_PRE || st.cmd == CMD_MRS) sinceClose <= SINCE_W'(1);
      else if (sinceClose != SINCE_SAT)           sinceClose <= sinceClose + 1'b1;
    end
  end

  p_miss_stays_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && busReq && !hit) |=> (state == S_IDLE));
  p_rcd_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RCD && (st.rdBeat || st.wrBeat)) |-> (sinceAct == SINCE_W'(TRCD)));
  p_close_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.cmd == CMD_ACT) |-> (sinceClose >= SINCE_W'(TRP + 1)));
  p_arm_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st.cmd == CMD_MRS && !armSet) |=> !armed);
endmodule

// File: rtl/sdseq_dp.sv
module sdseq_dp
  import sdseq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         st,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [ADDR_W-1:0]  cfgMask,
  input  logic [1:0]         cfgCasLat,
  input  logic [DATA_W-1:0]  sdDqIn,
  output logic               hit,
  output logic               rdIdle,
  output logic [3:0]         sdCmd,
  output logic [ROW_W-1:0]   sdAddr,
  output logic [DATA_W-1:0]  sdDqOut,
  output logic               sdDqOe,
  output logic               busAck,
  output logic [DATA_W-1:0]  busRdata
);
  localparam int SA_W = ROW_W;

  logic [COL_W-1:0]      colBase, beatCol;
  logic [SA_W-1:0]       addrNxt, preAddr;
  logic [RD_PIPE_D-1:0]  rdPipe, keep;
  logic                  capNow;

  assign hit = (((busAddr ^ cfgBase) & ~cfgMask) == '0);

  assign beatCol = st.line ? {colBase[COL_W-1:BEAT_W], st.beat} : colBase;

  always_comb begin
    preAddr         = '0;
    preAddr[AP_BIT] = 1'b1;
    case (st.addrSel)
      ASEL_ROW:  addrNxt = busAddr[COL_W+2 +: ROW_W];
      ASEL_MODE: addrNxt = busAddr[2 +: SA_W];
      ASEL_PRE:  addrNxt = preAddr;
      default:   addrNxt = SA_W'(beatCol);
    endcase
  end

  // Read pipe: bit i set means a READ was issued i+1 edges ago.
  for (genvar i = 0; i < RD_PIPE_D; i++) begin : g_keep
    assign keep[i] = (i <= int'(cfgCasLat));
  end
  assign capNow = rdPipe[cfgCasLat];
  assign rdIdle = (rdPipe == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdCmd    <= CMD_NOP;
      sdAddr   <= '0;
      sdDqOut  <= '0;
      sdDqOe   <= 1'b0;
      busAck   <= 1'b0;
      busRdata <= '0;
      colBase  <= '0;
      rdPipe   <= '0;
    end else begin
      sdCmd  <= st.cmd;
      sdAddr <= addrNxt;
      sdDqOe <= st.wrBeat;
      if (st.wrBeat) sdDqOut <= busWdata;
      if (st.latch)  colBase <= busAddr[2 +: COL_W];
      rdPipe <= {rdPipe[RD_PIPE_D-2:0], st.rdBeat} & keep;
      busAck <= st.wrBeat | st.modeAck | capNow;
      if (capNow) busRdata <= sdDqIn;
    end
  end

  p_oe_only_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    sdDqOe |-> (sdCmd == CMD_WR));
  p_col_ap_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sdCmd == CMD_RD || sdCmd == CMD_WR) |-> !sdAddr[AP_BIT]);
  p_mode_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sdCmd == CMD_MRS) |-> (sdAddr == $past(busAddr[2 +: SA_W])));
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdseq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int TRCD   = 2,
  parameter int TRP    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgMask,
  input  logic [1:0]        cfgCasLat,
  input  logic              armSet,
  output logic              armed,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic              busAck,
  output logic [DATA_W-1:0] busRdata,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ROW_W-1:0]  sdAddr,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              sdDqOe,
  input  logic [DATA_W-1:0] sdDqIn
);
  seqStrobe_t st;
  logic       hit, rdIdle;
  logic [3:0] sdCmd;

  sdseq_ctrl #(.TRCD(TRCD), .TRP(TRP)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busSize(busSize), .hit(hit), .rdIdle(rdIdle), .armSet(armSet),
    .st(st), .armed(armed)
  );

  sdseq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .busAddr(busAddr), .busWdata(busWdata),
    .cfgBase(cfgBase), .cfgMask(cfgMask), .cfgCasLat(cfgCasLat), .sdDqIn(sdDqIn),
    .hit(hit), .rdIdle(rdIdle), .sdCmd(sdCmd), .sdAddr(sdAddr),
    .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .busAck(busAck), .busRdata(busRdata)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = sdCmd;
endmodule

// File: tb/sdram_cmd_seq_tb.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb;
  localparam int TRCD = 2;
  localparam int TRP  = 3;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_MRS = 4'b0000;

  logic clk = 1'b0, rstN = 1'b0;
  logic [23:0] cfgBase = 24'h800000, cfgMask = 24'h0FFFFF;
  logic [1:0]  cfgCasLat = 2'd2;
  logic armSet = 1'b0, armed;
  logic busReq = 1'b0, busWrite = 1'b0;
  logic [1:0]  busSize = 2'd2;
  logic [23:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic busAck, sdCsN, sdRasN, sdCasN, sdWeN, sdDqOe;
  logic [11:0] sdAddr;
  logic [31:0] sdDqOut, sdDqIn = 32'hDEADBEEF;

  int total = 0, bad = 0, cyc = 0, curCl = 2;

  sdram_cmd_seq #(.TRCD(TRCD), .TRP(TRP)) u_dut (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgMask(cfgMask),
    .cfgCasLat(cfgCasLat), .armSet(armSet), .armed(armed),
    .busReq(busReq), .busWrite(busWrite), .busSize(busSize), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdAddr(sdAddr), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .sdDqIn(sdDqIn)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] rpat(input logic [7:0] col);
    return 32'h5A000000 ^ (32'(col) * 32'h00010101);
  endfunction
  function automatic logic [31:0] wpat(input logic [23:0] a, input int k);
    return {a[15:0], 16'(k) + 16'h00A0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Pin-level read model: data for a READ seen at negedge n is driven at negedge n+CL.
  int pendCnt[4];
  logic [31:0] pendDat[4];
  bit pendV[4];
  always @(negedge clk) begin
    logic [31:0] drv;
    drv = 32'hDEADBEEF;
    for (int i = 0; i < 4; i++)
      if (pendV[i]) begin
        pendCnt[i]--;
        if (pendCnt[i] == 0) begin drv = pendDat[i]; pendV[i] = 1'b0; end
      end
    sdDqIn = drv;
    if ({sdCsN, sdRasN, sdCasN, sdWeN} == C_RD) begin
      for (int i = 0; i < 4; i++)
        if (!pendV[i]) begin
          pendV[i] = 1'b1; pendCnt[i] = curCl; pendDat[i] = rpat(sdAddr[7:0]);
          break;
        end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Generic access driver and checker; all indices count negedges from the request.
  task automatic runAccess(input bit wr, input logic [1:0] sz, input logic [23:0] a,
                           input bit expMrs, input string tag);
    int actIdx = -1, preIdx = -1, mrsIdx = -1, nBeat = 0, nAck = 0, extra = 0, oeBad = 0;
    int beatAt[4], ackAt[4];
    logic [11:0] actRow = '0, mrsA = '0, beatCol[4];
    logic [31:0] beatDq[4], ackDat[4];
    logic [3:0] beatCmd[4];
    logic preA10 = 1'b0;
    int nb, expAcks;
    nb = (sz == 2'd3) ? 4 : 1;
    expAcks = expMrs ? 1 : nb;
    @(negedge clk);
    busReq = 1'b1; busWrite = wr; busSize = sz; busAddr = a; busWdata = wpat(a, 0);
    for (int i = 1; i <= 40; i++) begin
      logic [3:0] c;
      @(negedge clk);
      c = {sdCsN, sdRasN, sdCasN, sdWeN};
      case (c)
        C_NOP: ;
        C_ACT: if (actIdx < 0) begin actIdx = i; actRow = sdAddr; end else extra++;
        C_RD, C_WR: if (nBeat < 4) begin
          beatAt[nBeat] = i; beatCol[nBeat] = sdAddr; beatDq[nBeat] = sdDqOut;
          beatCmd[nBeat] = c; nBeat++;
        end else extra++;
        C_PRE: if (preIdx < 0) begin preIdx = i; preA10 = sdAddr[10]; end else extra++;
        C_MRS: if (mrsIdx < 0) begin mrsIdx = i; mrsA = sdAddr; end else extra++;
        default: extra++;
      endcase
      if (sdDqOe && c != C_WR) oeBad++;
      if (busAck) begin
        if (nAck < 4) begin ackAt[nAck] = i; ackDat[nAck] = busRdata; end
        nAck++;
        busWdata = wpat(a, nAck);
        if (nAck == expAcks) busReq = 1'b0;
      end
    end
    busReq = 1'b0;
    chk(nAck == expAcks, expMrs ? "R8" : (wr ? "R5" : "R6"), {tag, " ack count"}, nAck, expAcks);
    chk(extra == 0, "R2", {tag, " unexpected commands"}, extra, 0);
    if (expMrs) begin
      chk(mrsIdx == 1, "R8", {tag, " mode-set clock"}, mrsIdx, 1);
      chk(mrsA == a[13:2], "R8", {tag, " mode value"}, mrsA, a[13:2]);
      chk(actIdx < 0 && nBeat == 0 && preIdx < 0, "R8", {tag, " no row/column cmds"}, nBeat, 0);
      chk(nAck >= 1 && ackAt[0] == 1, "R8", {tag, " ack clock"}, ackAt[0], 1);
      chk(armed == 1'b0, "R8", {tag, " arm cleared"}, armed, 0);
    end else begin
      chk(actIdx == 1, "R3", {tag, " ACTIVE clock"}, actIdx, 1);
      chk(actRow == a[21:10], "R3", {tag, " row"}, actRow, a[21:10]);
      chk(nBeat == nb, "R4", {tag, " beat count"}, nBeat, nb);
      for (int k = 0; k < nBeat; k++) begin
        logic [7:0] ec;
        ec = (nb == 4) ? {a[9:4], 2'(k)} : a[9:2];
        chk(beatAt[k] == 1 + TRCD + k, "R3", {tag, " beat clock"}, beatAt[k], 1 + TRCD + k);
        chk(beatCol[k] == 12'(ec), "R4", {tag, " column"}, beatCol[k], ec);
        chk(beatCmd[k] == (wr ? C_WR : C_RD), "R2", {tag, " beat cmd"}, beatCmd[k], wr ? C_WR : C_RD);
        if (k < nAck && k < 4) begin
          if (wr) begin
            chk(beatDq[k] == wpat(a, k), "R5", {tag, " write data"}, beatDq[k], wpat(a, k));
            chk(ackAt[k] == beatAt[k], "R5", {tag, " write ack clock"}, ackAt[k], beatAt[k]);
          end else begin
            chk(ackAt[k] == beatAt[k] + curCl + 1, "R6", {tag, " read ack clock"},
                ackAt[k], beatAt[k] + curCl + 1);
            chk(ackDat[k] == rpat(ec), "R6", {tag, " read data"}, ackDat[k], rpat(ec));
          end
        end
      end
      chk(preIdx == 1 + TRCD + nb, "R7", {tag, " PRECHARGE clock"}, preIdx, 1 + TRCD + nb);
      chk(preA10 == 1'b1, "R7", {tag, " PRECHARGE bit 10"}, preA10, 1);
      chk(oeBad == 0, "R5", {tag, " oe outside WRITE"}, oeBad, 0);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk({sdCsN, sdRasN, sdCasN, sdWeN} == C_NOP, "R11", "reset cmd NOP",
        {sdCsN, sdRasN, sdCasN, sdWeN}, C_NOP);
    chk(!armed && !busAck && !sdDqOe, "R11", "reset flags", {armed, busAck, sdDqOe}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk({sdCsN, sdRasN, sdCasN, sdWeN} == C_NOP, "R2", "idle NOP",
        {sdCsN, sdRasN, sdCasN, sdWeN}, C_NOP);
  endtask

  task automatic pulseArm();
    @(negedge clk); armSet = 1'b1;
    @(negedge clk); armSet = 1'b0;
    chk(armed == 1'b1, "R8", "arm readback", armed, 1);
  endtask

  task automatic testMissKeepsArm();
    int cmds = 0, acks = 0;
    pulseArm();
    @(negedge clk);
    busReq = 1'b1; busWrite = 1'b0; busSize = 2'd2; busAddr = 24'hC01234;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if ({sdCsN, sdRasN, sdCasN, sdWeN} != C_NOP) cmds++;
      if (busAck) acks++;
    end
    busReq = 1'b0;
    chk(cmds == 0, "R1", "miss issues no command", cmds, 0);
    chk(acks == 0, "R1", "miss gets no ack", acks, 0);
    chk(armed == 1'b1, "R9", "miss keeps arm", armed, 1);
  endtask

  initial begin
    testReset();
    curCl = 1; cfgCasLat = 2'd1;
    runAccess(1'b0, 2'd2, 24'h812344, 1'b0, "rd word cl1");
    curCl = 2; cfgCasLat = 2'd2;
    runAccess(1'b0, 2'd3, 24'h8ABC58, 1'b0, "rd line cl2");
    curCl = 3; cfgCasLat = 2'd3;
    runAccess(1'b0, 2'd3, 24'h8F03A4, 1'b0, "rd line cl3");
    runAccess(1'b1, 2'd0, 24'h841237, 1'b0, "wr byte");
    runAccess(1'b1, 2'd3, 24'h8C0470, 1'b0, "wr line");
    testMissKeepsArm();
    runAccess(1'b0, 2'd2, 24'h800088, 1'b1, "mode-set via read");
    runAccess(1'b0, 2'd2, 24'h833310, 1'b0, "R10 normal after mode-set");
    pulseArm();
    runAccess(1'b1, 2'd3, 24'h800230, 1'b1, "mode-set via line write");
    runAccess(1'b1, 2'd2, 24'h8777FC, 1'b0, "R10 write after mode-set");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule